// File: doc/BRIEF.md
# Leaf Entry Permission Check and Reference/Change Updater

This block sits at the end of a radix page walk. It takes the leaf page table entry that the walker found, the kind of access (load, store or instruction fetch), the privilege state of the requester, whether the check is process-scoped or partition-scoped, and an authority-mask permission vector. From these it decides whether the access may proceed and builds a fault-cause vector. It also returns the permission set that a translation cache may record.

When the access passes, the block sets the reference bit in the entry. It sets the change bit as well, but only for stores. If the new entry differs from the old one, it issues a single write-back over a request/acknowledge memory write port and waits for the acknowledge. A load or fetch never gets write permission in the returned set. A later store therefore has to come back through the block, and that store sets the change bit. One cycle after the block finishes, it raises `done` for exactly one cycle.

Field layout of the entry:
- bits 2:0 are the access authority: bit 0 read, bit 1 write, bit 2 execute.
- bit 3 marks a privileged-only page.
- bits 5:4 hold the storage attribute; the value 2'b10 means non-idempotent I/O.
- bit 7 is the change bit.
- bit 8 is the reference bit.

Permission vectors use the same read/write/execute bit order as the authority field.

Access codes: 0 is load, 1 is store, 2 is fetch, and 3 is handled as a load.

Cause bits:
- bit 0: guarded no-execute.
- bit 1: protection fault.
- bit 2: the faulting access was a store.

Top module: `pte_perm_rc`

## Requirements
- R1: A fetch (code 2) to an entry whose attribute bits 5:4 equal 2'b10 faults with cause exactly 3'b001 and returned permission 3'b000. The entry is not written back. For loads and stores the attribute does not matter.
- R2: On a process-scoped check (`part_scoped`=0) where the entry's privileged bit 3 is 1 and `user_mode` is 1, the granted permission is empty.
- R3: On a process-scoped check with `user_mode`=0 and privileged bit 3 clear, the granted permission is the entry's bits 2:0 ANDed with `amr_perm`.
- R4: In every other case, including every partition-scoped check, the granted permission is the entry's bits 2:0 alone, and `amr_perm` has no effect.
- R5: A protection fault sets cause bit 1 when the needed right is missing from the granted set. A load needs read (bit 0), a store needs write (bit 1) and a fetch needs execute (bit 2).
- R6: When a store faults, cause bit 2 is also set. When a load or fetch faults, cause bit 2 stays clear, and on a passing access the cause is 3'b000.
- R7: On a passing access, `new_pte` equals the entry with bit 8 set, and with bit 7 set too when the access is a store. On a fault, `new_pte` equals the original entry.
- R8: The returned `perm` is the granted set, with the write bit cleared for every access that is not a store.
- R9: A write-back (`wr_req`=1 with `wr_addr`=`pte_addr` and `wr_data`=`new_pte`) is raised only when the entry changed. `wr_req`, `wr_addr` and `wr_data` stay steady until the cycle in which `wr_ack` is sampled high.
- R10: `done` rises for exactly one cycle. When there is no write-back it rises in the cycle after the `start` edge; otherwise it rises in the cycle after the acknowledge edge.
- R11: After reset, `done`, `fault` and `wr_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; sampled only while idle |
| pte | input | PTE_W | Leaf entry under check |
| pte_addr | input | ADDR_W | Address the entry was read from |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| user_mode | input | 1 | Requester is in problem (user) state |
| part_scoped | input | 1 | Check is partition-scoped |
| amr_perm | input | 3 | Authority-mask permission, read/write/execute |
| wr_ack | input | 1 | Write-back accepted |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Access denied |
| cause | output | CAUSE_W | Fault-cause vector |
| perm | output | 3 | Returned permission set |
| new_pte | output | PTE_W | Updated entry |
| wr_req | output | 1 | Write-back request |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | PTE_W | Write-back data |

## Verification
The assertions assume two things about the environment. First, `start` is only raised while the block is idle. Second, `wr_ack` is only raised while `wr_req` is high. The write-stability property relies on the second assumption. The bench meets both assumptions: each scenario task pulses `start` once and then waits for `done`, and it drives the acknowledge only after it has seen `wr_req` at a falling edge. The acknowledge delay changes between scenarios, so the hold period ranges from zero to several cycles.

// File: rtl/pte_rc_pkg.sv
package pte_rc_pkg;
   localparam int PERM_W   = 3;
   localparam int P_RD     = 0;
   localparam int P_WR     = 1;
   localparam int P_EX     = 2;
   localparam int PTE_PRIV = 3;
   localparam int ATT_LO   = 4;
   localparam logic [1:0] ATT_NIIO = 2'b10;
   localparam int PTE_CHG  = 7;
   localparam int PTE_REF  = 8;
   localparam int CS_GUARD = 0;
   localparam int CS_PROT  = 1;
   localparam int CS_STORE = 2;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WB   = 2'd1,
      ST_DONE = 2'd2
   } state_e;
endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
   import pte_rc_pkg::*;
#(
   parameter int PTE_W     = 64,
   parameter int CAUSE_W   = 3,
   parameter bit AMR_APPLY = 1'b1
) (
   input  logic [PTE_W-1:0]   pte,
   input  logic [1:0]         acc,
   input  logic               user,
   input  logic               part,
   input  logic [PERM_W-1:0]  amr,
   output logic [PERM_W-1:0]  perm,
   output logic [CAUSE_W-1:0] cause,
   output logic               fault
);
   logic [PERM_W-1:0] eaa, eaa_masked, granted, need;
   logic guard, prot, is_store;

   assign eaa = pte[PERM_W-1:0];

   generate
      if (AMR_APPLY) begin : g_amr
         for (genvar i = 0; i < PERM_W; i++) begin : g_bit
            assign eaa_masked[i] = eaa[i] & amr[i];
         end
      end else begin : g_noamr
         assign eaa_masked = eaa;
      end
   endgenerate

   always_comb begin
      is_store = (acc == ACC_STORE);
      guard    = (acc == ACC_FETCH) && (pte[ATT_LO+1:ATT_LO] == ATT_NIIO);
      if (guard)
         granted = '0;
      else if (!part && pte[PTE_PRIV] && user)
         granted = '0;
      else if (user || pte[PTE_PRIV] || part)
         granted = eaa;
      else
         granted = eaa_masked;

      need = '0;
      case (acc)
         ACC_STORE: need[P_WR] = 1'b1;
         ACC_FETCH: need[P_EX] = 1'b1;
         default:   need[P_RD] = 1'b1;
      endcase
      prot  = !guard && ((need & ~granted) != '0);
      fault = guard || prot;

      cause           = '0;
      cause[CS_GUARD] = guard;
      cause[CS_PROT]  = prot;
      cause[CS_STORE] = fault && is_store;

      perm = granted;
      if (!is_store) perm[P_WR] = 1'b0;
   end
endmodule

// File: rtl/pte_rc_update.sv
module pte_rc_update
   import pte_rc_pkg::*;
#(
   parameter int PTE_W = 64
) (
   input  logic [PTE_W-1:0] pte,
   input  logic             is_store,
   output logic [PTE_W-1:0] npte,
   output logic             changed
);
   always_comb begin
      npte          = pte;
      npte[PTE_REF] = 1'b1;
      if (is_store) npte[PTE_CHG] = 1'b1;
      changed = (npte != pte);
   end
endmodule

// File: rtl/pte_perm_rc.sv
module pte_perm_rc
   import pte_rc_pkg::*;
#(
   parameter int PTE_W     = 64,
   parameter int ADDR_W    = 48,
   parameter int CAUSE_W   = 3,
   parameter bit AMR_APPLY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PTE_W-1:0]   pte,
   input  logic [ADDR_W-1:0]  pte_addr,
   input  logic [1:0]         acc_type,
   input  logic               user_mode,
   input  logic               part_scoped,
   input  logic [2:0]         amr_perm,
   input  logic               wr_ack,
   output logic               done,
   output logic               fault,
   output logic [CAUSE_W-1:0] cause,
   output logic [2:0]         perm,
   output logic [PTE_W-1:0]   new_pte,
   output logic               wr_req,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [PTE_W-1:0]   wr_data
);
   initial begin
      if (PTE_W < PTE_REF + 1) $error("PTE_W too small for the reference bit");
      if (CAUSE_W < CS_STORE + 1) $error("CAUSE_W too small for the cause bits");
      if (ADDR_W < 1) $error("ADDR_W must be positive");
   end

   logic [PERM_W-1:0]  e_perm;
   logic [CAUSE_W-1:0] e_cause;
   logic               e_fault, u_changed;
   logic [PTE_W-1:0]   u_npte;

   pte_perm_eval #(.PTE_W(PTE_W), .CAUSE_W(CAUSE_W), .AMR_APPLY(AMR_APPLY)) u_eval (
      .pte(pte), .acc(acc_type), .user(user_mode), .part(part_scoped),
      .amr(amr_perm), .perm(e_perm), .cause(e_cause), .fault(e_fault));

   pte_rc_update #(.PTE_W(PTE_W)) u_upd (
      .pte(pte), .is_store(acc_type == ACC_STORE),
      .npte(u_npte), .changed(u_changed));

   state_e             state;
   logic [PTE_W-1:0]   pte_q, npte_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [PERM_W-1:0]  perm_q;
   logic [CAUSE_W-1:0] cause_q;
   logic               fault_q, store_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pte_q   <= '0;
         npte_q  <= '0;
         addr_q  <= '0;
         perm_q  <= '0;
         cause_q <= '0;
         fault_q <= 1'b0;
         store_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               pte_q   <= pte;
               addr_q  <= pte_addr;
               perm_q  <= e_perm;
               cause_q <= e_cause;
               fault_q <= e_fault;
               store_q <= (acc_type == ACC_STORE);
               npte_q  <= e_fault ? pte : u_npte;
               state   <= (!e_fault && u_changed) ? ST_WB : ST_DONE;
            end
            ST_WB:   if (wr_ack) state <= ST_DONE;
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done    = (state == ST_DONE);
   assign fault   = done && fault_q;
   assign cause   = cause_q;
   assign perm    = perm_q;
   assign new_pte = npte_q;
   assign wr_req  = (state == ST_WB);
   assign wr_addr = addr_q;
   assign wr_data = npte_q;

   assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
   assert_wr_changed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (wr_data != pte_q));
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_ref_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> new_pte[PTE_REF]);
   assert_no_wr_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !store_q) |-> !perm[P_WR]);
   assert_guard_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cause[CS_GUARD]) |-> (perm == '0 && !wr_req));
   assert_store_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> (cause == '0));
endmodule

// File: tb/pte_perm_rc_test.sv
`timescale 1ns/1ps
module pte_perm_rc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] pte = '0;
   logic [47:0] pte_addr = '0;
   logic [1:0]  acc_type = '0;
   logic        user_mode = 1'b0;
   logic        part_scoped = 1'b0;
   logic [2:0]  amr_perm = '0;
   logic        wr_ack = 1'b0;
   logic        done, fault, wr_req;
   logic [2:0]  cause, perm;
   logic [63:0] new_pte, wr_data;
   logic [47:0] wr_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pte_perm_rc uut (
      .clk(clk), .rst_n(rst_n), .start(start), .pte(pte), .pte_addr(pte_addr),
      .acc_type(acc_type), .user_mode(user_mode), .part_scoped(part_scoped),
      .amr_perm(amr_perm), .wr_ack(wr_ack), .done(done), .fault(fault),
      .cause(cause), .perm(perm), .new_pte(new_pte), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_data(wr_data));

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // Expected results derived from the requirements
   task automatic model(input logic [63:0] p, input logic [1:0] acc, input logic user,
                        input logic part, input logic [2:0] amr,
                        output logic [2:0] e_perm, output logic [2:0] e_cause,
                        output logic [63:0] e_np, output logic e_wb);
      logic [2:0] g, need;
      logic guard, prot;
      guard = (acc == 2'd2) && (p[5:4] == 2'b10);
      if (guard) g = 3'b000;
      else if (!part && p[3] && user) g = 3'b000;
      else if (user || p[3] || part) g = p[2:0];
      else g = p[2:0] & amr;
      need = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b100 : 3'b001;
      prot = !guard && ((need & ~g) != 3'b000);
      e_cause = {(guard || prot) && acc == 2'd1, prot, guard};
      e_perm = g;
      if (acc != 2'd1) e_perm[1] = 1'b0;
      e_np = p;
      if (!(guard || prot)) begin
         e_np[8] = 1'b1;
         if (acc == 2'd1) e_np[7] = 1'b1;
      end
      e_wb = (e_np != p);
   endtask

   task automatic run(input string req, input logic [63:0] p, input logic [47:0] a,
                      input logic [1:0] acc, input logic user, input logic part,
                      input logic [2:0] amr, input int ack_dly);
      logic [2:0] e_perm, e_cause;
      logic [63:0] e_np;
      logic e_wb;
      model(p, acc, user, part, amr, e_perm, e_cause, e_np, e_wb);
      @(negedge clk);
      pte = p; pte_addr = a; acc_type = acc; user_mode = user;
      part_scoped = part; amr_perm = amr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      pte = '0; amr_perm = '0;
      chk({req, " wr_req raised iff entry changed (R9)"}, wr_req, e_wb);
      if (e_wb) begin
         chk({req, " wr_addr (R9)"}, wr_addr, a);
         chk({req, " wr_data (R9)"}, wr_data, e_np);
         for (int k = 0; k < ack_dly; k++) begin
            @(negedge clk);
            chk({req, " wr_req held until ack (R9)"}, {wr_req, done}, 2'b10);
            chk({req, " wr_data steady (R9)"}, wr_data, e_np);
         end
         wr_ack = 1'b1;
         @(negedge clk);
         wr_ack = 1'b0;
      end
      chk({req, " done timing (R10)"}, done, 1'b1);
      chk({req, " fault"}, fault, (e_cause != 3'b000));
      chk({req, " cause"}, cause, e_cause);
      chk({req, " perm"}, perm, e_perm);
      chk({req, " new_pte (R7)"}, new_pte, e_np);
      @(negedge clk);
      chk({req, " done one cycle (R10)"}, {done, wr_req}, 2'b00);
   endtask

   task automatic t_reset;
      chk("R11 reset done/fault/wr_req", {done, fault, wr_req}, 3'b000);
   endtask
   task automatic t_load_first;   // R7 R8: reference bit newly set
      run("R7 load sets ref", 64'h0000_1234_0000_0007, 48'h1000, 2'd0, 0, 0, 3'b111, 0);
   endtask
   task automatic t_load_no_wb;   // R9 R10: already referenced
      run("R10 load no change", 64'h0000_1234_0000_0107, 48'h1008, 2'd0, 0, 0, 3'b111, 0);
   endtask
   task automatic t_store_wb;     // R7: change bit set, slow ack
      run("R9 store sets chg", 64'h0000_00AB_0000_0103, 48'h2010, 2'd1, 0, 0, 3'b111, 5);
   endtask
   task automatic t_store_clean;
      run("R9 store already dirty", 64'h0000_00AB_0000_0183, 48'h2018, 2'd1, 0, 0, 3'b111, 0);
   endtask
   task automatic t_niio_fetch;
      run("R1 io fetch guarded", 64'h0000_0000_0000_0027, 48'h3000, 2'd2, 0, 0, 3'b111, 0);
   endtask
   task automatic t_niio_load;
      run("R1 io load unaffected", 64'h0000_0000_0000_0021, 48'h3008, 2'd0, 0, 0, 3'b111, 2);
   endtask
   task automatic t_user_priv;
      run("R2 user priv page", 64'h0000_0000_0000_010F, 48'h4000, 2'd0, 1, 0, 3'b111, 0);
   endtask
   task automatic t_user_priv_part;
      run("R4 partition priv page", 64'h0000_0000_0000_000F, 48'h4008, 2'd0, 1, 1, 3'b000, 1);
   endtask
   task automatic t_amr_mask_store;
      run("R3 amr masks store R6", 64'h0000_0000_0000_0107, 48'h5000, 2'd1, 0, 0, 3'b001, 0);
   endtask
   task automatic t_amr_mask_fetch;
      run("R3 amr allows fetch", 64'h0000_0000_0000_0104, 48'h5008, 2'd2, 0, 0, 3'b100, 0);
   endtask
   task automatic t_priv_sup;
      run("R4 supervisor priv ignores amr", 64'h0000_0000_0000_0108, 48'h5010, 2'd0, 0, 0, 3'b000, 0);
   endtask
   task automatic t_user_nonpriv;
      run("R4 user nonpriv ignores amr", 64'h0000_0000_0000_0007, 48'h5018, 2'd1, 1, 0, 3'b000, 3);
   endtask
   task automatic t_fetch_noexec;
      run("R5 fetch no exec", 64'h0000_0000_0000_0103, 48'h6000, 2'd2, 0, 1, 3'b111, 0);
   endtask
   task automatic t_load_prot;
      run("R6 load prot no store flag", 64'h0000_0000_0000_0006, 48'h6008, 2'd0, 0, 1, 3'b111, 0);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_first();
      t_load_no_wb();
      t_store_wb();
      t_store_clean();
      t_niio_fetch();
      t_niio_load();
      t_user_priv();
      t_user_priv_part();
      t_amr_mask_store();
      t_amr_mask_fetch();
      t_priv_sup();
      t_user_nonpriv();
      t_fetch_noexec();
      t_load_prot();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule